// File: doc/BRIEF.md
# SPI Two-Stage Baud Generator

This block sets the bit rate of an SPI master. The main clock first passes through a power-of-two prescaler chosen by a 2-bit coarse field, and then through a linear divider chosen by a 6-bit fine field. At the end of every SCK half-period the block pulses a one-cycle tick, which the shifter uses to toggle SCK. One tick period is (2 << DIV) * (BRG + 1) main-clock cycles, so SCK runs at main / ((2 << DIV) * 2 * (BRG + 1)).

Software can give the fields in two ways. It can give a divide ratio (main clock rate over target SCK rate), which a combinational solver turns into legal fields and clamps when the ratio is out of range. It can also write both fields directly. New fields are shown on the outputs at once. The counters use them only when the half-period in progress has finished, so SCK never gets a shortened phase. While the enable is low the counters hold at zero and a pending setting is used at once.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset the fields are DIV=0 and BRG=4, out_of_range is 0, and sck_tick stays 0 while enable is low.
- R2: On a ratio load the solver tries DIV = 0, 1, 2, 3 in that order and computes q = ratio >> (DIV+2). It picks the first DIV with q <= 64, sets BRG = q - 1 and clears out_of_range. The fields appear on the outputs the cycle after the strobe.
- R3: If ratio >> 2 is below 5 (the rate is too fast), the solver gives DIV=0, BRG=4 and sets out_of_range to 1.
- R4: If no DIV fits (ratio >> 5 above 64, the rate is too slow), the solver gives DIV=3, BRG=63 and sets out_of_range to 1.
- R5: While enabled, sck_tick is high for exactly one cycle every (2 << DIV) * (BRG + 1) cycles.
- R6: A direct load copies div_in and brg_in to the fields. A brg_in below 4 is replaced by 4 and sets out_of_range; otherwise out_of_range is cleared.
- R7: When both strobes are high in the same cycle, the ratio load wins.
- R8: A load made during a half-period does not shorten it. The interval in progress keeps the old length and the next interval uses the new fields.
- R9: While enable is low no tick is produced and the counters hold at zero. After enable rises, the first tick comes exactly one period later.
- R10: Without a load strobe, the fields and out_of_range do not change, even when ratio and the direct inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider chain |
| load_ratio | input | 1 | Strobe: solve fields from ratio |
| ratio | input | RATIO_W | Requested main-clock to SCK divide ratio |
| load_direct | input | 1 | Strobe: take div_in and brg_in |
| div_in | input | 2 | Direct prescaler select |
| brg_in | input | 6 | Direct fine divider value |
| sck_tick | output | 1 | One-cycle pulse per SCK half-period |
| div_sel | output | 2 | Selected prescaler field |
| brg_sel | output | 6 | Selected fine divider field |
| out_of_range | output | 1 | Last load was clamped |

## Verification
The hardest case to reach is a load that arrives part way through a half-period. Only that case shows whether the counters switch to the new fields early and produce a runt phase. The bench first synchronises to a tick, counts three edges into the interval and then loads a much slower setting. It checks that the interval in progress still has the old length and that the interval after it has the new length. The two solver boundaries next to each clamp (ratios 19/20 and 2079/2080) are applied as table vectors. Each vector also checks its resulting tick period.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int DIV_W     = 2;
  localparam int BRG_W     = 6;
  localparam int BRG_FLOOR = 4;
  localparam int DIV_STEPS = 1 << DIV_W;
  localparam int BRG_TOP   = (1 << BRG_W) - 1;
  localparam int PRE_W     = DIV_STEPS;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BRG_W-1:0] brg;
  } baud_cfg_t;

  localparam baud_cfg_t CFG_RESET = '{div: '0, brg: BRG_W'(BRG_FLOOR)};
endpackage

// File: rtl/spi_baud_solver.sv
module spi_baud_solver
  import spi_baud_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic [RATIO_W-1:0] ratio,
  output baud_cfg_t          cfg,
  output logic               clamped
);
  localparam logic [RATIO_W-1:0] Q_LOW  = RATIO_W'(BRG_FLOOR + 1);
  localparam logic [RATIO_W-1:0] Q_HIGH = RATIO_W'(BRG_TOP + 1);

  logic [RATIO_W-1:0]   quot [DIV_STEPS];
  logic [DIV_STEPS-1:0] too_fast;
  logic [DIV_STEPS-1:0] fits;

  // one candidate per prescaler setting
  generate
    for (genvar g = 0; g < DIV_STEPS; g++) begin : g_try
      assign quot[g]     = ratio >> (g + 2);
      assign too_fast[g] = quot[g] < Q_LOW;
      assign fits[g]     = quot[g] <= Q_HIGH;
    end
  endgenerate

  // priority pick: lowest prescaler first, slow clamp as fallback
  always_comb begin
    logic done;
    done    = 1'b0;
    cfg.div = DIV_W'(DIV_STEPS - 1);
    cfg.brg = BRG_W'(BRG_TOP);
    clamped = 1'b1;
    for (int d = 0; d < DIV_STEPS; d++) begin
      if (!done) begin
        if (too_fast[d]) begin
          cfg.div = DIV_W'(d);
          cfg.brg = BRG_W'(BRG_FLOOR);
          clamped = 1'b1;
          done    = 1'b1;
        end else if (fits[d]) begin
          cfg.div = DIV_W'(d);
          cfg.brg = BRG_W'(quot[d] - 1'b1);
          clamped = 1'b0;
          done    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_baud_cfg.sv
module spi_baud_cfg
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ratio,
  input  baud_cfg_t        solved,
  input  logic             solved_clamp,
  input  logic             load_direct,
  input  logic [DIV_W-1:0] div_in,
  input  logic [BRG_W-1:0] brg_in,
  input  logic             apply,
  output baud_cfg_t        sel,
  output logic             clamp,
  output logic             pend
);
  baud_cfg_t sel_n;
  logic      clamp_n;
  logic      pend_n;

  always_comb begin
    sel_n   = sel;
    clamp_n = clamp;
    pend_n  = pend & ~apply;
    if (load_ratio) begin
      sel_n   = solved;
      clamp_n = solved_clamp;
      pend_n  = 1'b1;
    end else if (load_direct) begin
      sel_n.div = div_in;
      pend_n    = 1'b1;
      if (brg_in < BRG_W'(BRG_FLOOR)) begin
        sel_n.brg = BRG_W'(BRG_FLOOR);
        clamp_n   = 1'b1;
      end else begin
        sel_n.brg = brg_in;
        clamp_n   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel   <= CFG_RESET;
      clamp <= 1'b0;
      pend  <= 1'b0;
    end else begin
      sel   <= sel_n;
      clamp <= clamp_n;
      pend  <= pend_n;
    end
  end
endmodule

// File: rtl/spi_baud_divider.sv
module spi_baud_divider
  import spi_baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      pend,
  input  baud_cfg_t pend_cfg,
  output logic      tick,
  output logic      apply
);
  baud_cfg_t        act, act_n;
  logic [PRE_W-1:0] pre_cnt, pre_n, pre_lim;
  logic [BRG_W-1:0] fine_cnt, fine_n;
  logic             pre_term, fine_term, wrap, tick_n;

  always_comb begin
    pre_lim   = PRE_W'((32'd2 << act.div) - 32'd1);
    pre_term  = pre_cnt == pre_lim;
    fine_term = fine_cnt == act.brg;
    wrap      = enable & pre_term & fine_term;
    apply     = wrap | ~enable;
    tick_n    = wrap;
    act_n     = (apply && pend) ? pend_cfg : act;
    pre_n     = pre_cnt;
    fine_n    = fine_cnt;
    if (!enable) begin
      pre_n  = '0;
      fine_n = '0;
    end else if (pre_term) begin
      pre_n  = '0;
      fine_n = fine_term ? '0 : fine_cnt + 1'b1;
    end else begin
      pre_n  = pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= CFG_RESET;
      pre_cnt  <= '0;
      fine_cnt <= '0;
      tick     <= 1'b0;
    end else begin
      act      <= act_n;
      pre_cnt  <= pre_n;
      fine_cnt <= fine_n;
      tick     <= tick_n;
    end
  end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               load_ratio,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               load_direct,
  input  logic [DIV_W-1:0]   div_in,
  input  logic [BRG_W-1:0]   brg_in,
  output logic               sck_tick,
  output logic [DIV_W-1:0]   div_sel,
  output logic [BRG_W-1:0]   brg_sel,
  output logic               out_of_range
);
  baud_cfg_t solved, sel;
  logic      solved_clamp, pend, apply;

  spi_baud_solver #(.RATIO_W(RATIO_W)) u_solver (
    .ratio   (ratio),
    .cfg     (solved),
    .clamped (solved_clamp)
  );

  spi_baud_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_ratio   (load_ratio),
    .solved       (solved),
    .solved_clamp (solved_clamp),
    .load_direct  (load_direct),
    .div_in       (div_in),
    .brg_in       (brg_in),
    .apply        (apply),
    .sel          (sel),
    .clamp        (out_of_range),
    .pend         (pend)
  );

  spi_baud_divider u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .pend     (pend),
    .pend_cfg (sel),
    .tick     (sck_tick),
    .apply    (apply)
  );

  assign div_sel = sel.div;
  assign brg_sel = sel.brg;
endmodule

// File: rtl/spi_baud_gen_chk.sv
module spi_baud_gen_chk
  import spi_baud_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               load_ratio,
  input logic [RATIO_W-1:0] ratio,
  input logic               load_direct,
  input logic [DIV_W-1:0]   div_in,
  input logic [BRG_W-1:0]   brg_in,
  input logic               sck_tick,
  input logic [DIV_W-1:0]   div_sel,
  input logic [BRG_W-1:0]   brg_sel,
  input logic               out_of_range
);
  a_r3_fast_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ratio && (ratio >> 2) < (BRG_FLOOR + 1)) |=>
      (out_of_range && div_sel == '0 && brg_sel == BRG_W'(BRG_FLOOR)));

  a_r4_slow_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ratio && (ratio >> 5) > (BRG_TOP + 1)) |=>
      (out_of_range && div_sel == DIV_W'(DIV_STEPS - 1) && brg_sel == BRG_W'(BRG_TOP)));

  a_r5_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sck_tick |=> !sck_tick);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sck_tick);

  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ratio && !load_direct) |=> $stable({div_sel, brg_sel, out_of_range}));

  a_r6_brg_floor: assert property (@(posedge clk) disable iff (!rst_n)
    brg_sel >= BRG_W'(BRG_FLOOR));
endmodule

bind spi_baud_gen spi_baud_gen_chk #(.RATIO_W(RATIO_W)) u_chk (.*);

// File: tb/sim_spi_baud_gen.sv
`timescale 1ns/1ps
module sim_spi_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n, enable, load_ratio, load_direct;
  logic [15:0] ratio;
  logic [1:0]  div_in;
  logic [5:0]  brg_in;
  logic        sck_tick, out_of_range;
  logic [1:0]  div_sel;
  logic [5:0]  brg_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spi_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load_ratio(load_ratio),
    .ratio(ratio), .load_direct(load_direct), .div_in(div_in), .brg_in(brg_in),
    .sck_tick(sck_tick), .div_sel(div_sel), .brg_sel(brg_sel),
    .out_of_range(out_of_range)
  );

  // {ratio, div, brg, oor, tick period}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {16'd0,     2'd0, 6'd4,  1'b1, 11'd10},
    {16'd19,    2'd0, 6'd4,  1'b1, 11'd10},
    {16'd20,    2'd0, 6'd4,  1'b0, 11'd10},
    {16'd100,   2'd0, 6'd24, 1'b0, 11'd50},
    {16'd259,   2'd0, 6'd63, 1'b0, 11'd128},
    {16'd260,   2'd1, 6'd31, 1'b0, 11'd128},
    {16'd600,   2'd2, 6'd36, 1'b0, 11'd296},
    {16'd1000,  2'd2, 6'd61, 1'b0, 11'd496},
    {16'd2079,  2'd3, 6'd63, 1'b0, 11'd1024},
    {16'd2080,  2'd3, 6'd63, 1'b1, 11'd1024},
    {16'd65535, 2'd3, 6'd63, 1'b1, 11'd1024}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_fields(input string req, input int d, input int b, input int o);
    check(div_sel == d[1:0], req, "div_sel", div_sel, d);
    check(brg_sel == b[5:0], req, "brg_sel", brg_sel, b);
    check(out_of_range == o[0], req, "out_of_range", out_of_range, o);
  endtask

  // counts rising edges until a tick is seen at a falling edge
  task automatic gap(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!sck_tick && n < 5000);
  endtask

  task automatic pulse_ratio(input logic [15:0] r);
    ratio = r; load_ratio = 1'b1;
    @(negedge clk); load_ratio = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n, ticks;
    rst_n = 1'b0; enable = 1'b0; load_ratio = 1'b0; load_direct = 1'b0;
    ratio = '0; div_in = '0; brg_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_fields("R1", 0, 4, 0);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sck_tick) ticks++; end
    check(ticks == 0, "R1", "ticks while idle", ticks, 0);

    // R9: first tick one full period after enable
    enable = 1'b1;
    gap(n); check(n == 10, "R9", "first tick latency", n, 10);
    gap(n); check(n == 10, "R5", "reset period", n, 10);

    // table walk: R2 R3 R4 fields and R5 periods
    for (int v = 0; v < NV; v++) begin
      string tag;
      int    ed, eb, eo, ep;
      ed = int'(VEC[v][18:17]); eb = int'(VEC[v][16:11]);
      eo = int'(VEC[v][10]);    ep = int'(VEC[v][9:0]) | (int'(VEC[v][10]) ? 0 : 0);
      ep = int'(VEC[v][10:0]) & 11'h7ff;
      ep = int'({VEC[v][10:0]}) ;
      ep = int'(VEC[v][10:0]);
      eo = int'(VEC[v][11]);
      eb = int'(VEC[v][17:12]);
      ed = int'(VEC[v][19:18]);
      tag = (eo == 0) ? "R2" : (ed == 0 ? "R3" : "R4");
      pulse_ratio(VEC[v][35:20]);
      check_fields(tag, ed, eb, eo);
      gap(n); gap(n); gap(n);
      check(n == ep, "R5", "tick period", n, ep);
    end

    // R8: load mid-interval must not shorten the running half-period
    pulse_ratio(16'd20);
    gap(n); gap(n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 3) begin ratio = 16'd100; load_ratio = 1'b1; end
      else load_ratio = 1'b0;
    end while (!sck_tick && n < 5000);
    load_ratio = 1'b0;
    check(n == 10, "R8", "interval holding load", n, 10);
    gap(n); check(n == 50, "R8", "first new interval", n, 50);

    // R6: direct load with floor clamp, then legal direct load
    div_in = 2'd1; brg_in = 6'd2; load_direct = 1'b1;
    @(negedge clk); load_direct = 1'b0;
    check_fields("R6", 1, 4, 1);
    div_in = 2'd2; brg_in = 6'd10; load_direct = 1'b1;
    @(negedge clk); load_direct = 1'b0;
    check_fields("R6", 2, 10, 0);
    gap(n); gap(n); gap(n);
    check(n == 88, "R6", "direct period", n, 88);

    // R7: both strobes, ratio load wins
    ratio = 16'd100; div_in = 2'd3; brg_in = 6'd50;
    load_ratio = 1'b1; load_direct = 1'b1;
    @(negedge clk); load_ratio = 1'b0; load_direct = 1'b0;
    check_fields("R7", 0, 24, 0);

    // R10: inputs wiggle without strobes
    for (int i = 0; i < 30; i++) begin
      ratio = 16'(i * 977); div_in = 2'(i); brg_in = 6'(i * 5);
      @(negedge clk);
    end
    check_fields("R10", 0, 24, 0);

    // R9: disable, load while idle, re-enable
    enable = 1'b0;
    pulse_ratio(16'd20);
    ticks = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck_tick) ticks++; end
    check(ticks == 0, "R9", "ticks while disabled", ticks, 0);
    enable = 1'b1;
    gap(n); check(n == 10, "R9", "latency after re-enable", n, 10);

    finish_run();
  end
endmodule